// File: doc/BRIEF.md
# Two-Wire Bus Target with Composite Node Address

This block is the byte-level target side of an I2C bus. The system clock oversamples the bus wires. The block drives only pull-down enables: one for SDA, and an optional one that stretches SCL. It recognises START, repeated START and STOP. It shifts bytes in and out MSB first and answers each byte in the ninth, acknowledge clock. Received bytes leave the block as single-cycle strobes. Bytes to be read come from a valid/take handshake supplied by the surrounding logic.

The node address has seven bits. The two upper bits are fixed at one. Four bits come from a programmable input, and the lowest bit comes from a board strap pin, so up to 32 nodes can share one bus. The all-zero general-call address is also acknowledged for writes, and bytes received under it are flagged. Each transfer may carry only a limited number of data bytes after the address byte. Any byte beyond that limit is not acknowledged.

Top module: `i2c_node_target`

## Requirements
- R1: While reset is high and after it is released, with no bus activity, `sda_oe` and `scl_hold` are low and `rx_valid`, `rx_end` and `tx_take` stay low.
- R2: The node address, MSB first, is `{1,1,node_prog[3:0],node_strap}`, and the R/W bit follows in the LSB of the first byte after START. A matching address is acknowledged, meaning SDA is pulled low through the ninth clock. A non-matching address leaves SDA released in that slot, and no data byte of the transfer is reported.
- R3: The address 000_0000 with R/W=0 is acknowledged. Data bytes received under it carry `rx_gcall`=1, while bytes sent to the node address carry `rx_gcall`=0.
- R4: In a write transfer, each data byte is sampled MSB first on SCL rising edges and acknowledged. It appears as a one-cycle `rx_valid` with `rx_data`. `rx_first` is high only with the first data byte after the address.
- R5: At most MAX_BYTES data bytes (default 8) are accepted per transfer. Every later byte is not acknowledged and is not reported on `rx_valid`.
- R6: With R/W=1, each byte is loaded from `tx_data` while `tx_valid` is high, with a one-cycle `tx_take`, and shifted out MSB first. A master ACK asks for the next byte. After a master NACK the target releases SDA and takes no further byte.
- R7: While a read byte is due and `tx_valid` is low, `scl_hold` holds SCL low. It is released in the cycle the byte is loaded.
- R8: A START at any point, including in the middle of a byte, restarts address reception.
- R9: `rx_end` pulses once when a STOP or a repeated START closes a write transfer that delivered at least one data byte. A START followed directly by STOP produces no strobe at all.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: `rx_first` never appears without `rx_valid`, and `tx_take` only follows a cycle with `tx_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_hold | output | 1 | Pull SCL low when 1 (clock stretch) |
| node_prog | input | 4 | Programmable address bits |
| node_strap | input | 1 | Strap-pin address bit (LSB of address) |
| rx_valid | output | 1 | One-cycle strobe: received byte on rx_data |
| rx_data | output | 8 | Received data byte |
| rx_first | output | 1 | Byte is the first data byte of the transfer |
| rx_gcall | output | 1 | Byte arrived under the general-call address |
| rx_end | output | 1 | One-cycle strobe: write transfer closed |
| tx_data | input | 8 | Byte to transmit on the next read slot |
| tx_valid | input | 1 | tx_data is ready |
| tx_take | output | 1 | One-cycle strobe: tx_data was loaded |

## Verification
Each SCL edge takes two synchroniser cycles and one edge-detect cycle before the state machine acts on it. A received-byte strobe therefore appears about four system cycles after the eighth rising SCL edge. The acknowledge drive on SDA starts about three cycles after the following SCL fall. The bench model master leaves at least twelve system cycles between an SCL edge and any SDA change, and samples SDA in the middle of the SCL high phase, long after the target has settled. Strobes are counted at falling clock edges and compared only once a bus operation has finished. The stretch check samples `scl_hold` a few hundred cycles into a deliberate stall, and after a master NACK it waits eight cycles before looking at `sda_oe`.

// File: rtl/i2c_node_pkg.sv
package i2c_node_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACKW,
    ST_ADDR_ACK,
    ST_WR_BIT,
    ST_WR_ACKW,
    ST_WR_ACK,
    ST_RD_LOAD,
    ST_RD_BIT,
    ST_RD_ACKW,
    ST_RD_ACKD
  } tgt_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } line_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_node_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_i,
  input  logic     sda_i,
  output line_ev_t ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_comb begin
    ev.scl      = scl_s;
    ev.sda      = sda_s;
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int ADDR_W = 7,
  parameter int FIX_W  = 2,
  parameter logic [FIX_W-1:0] FIXED_BITS = '1,
  localparam int PROG_W = ADDR_W - FIX_W - 1
) (
  input  logic [ADDR_W:0]   cand,
  input  logic [PROG_W-1:0] prog,
  input  logic              strap,
  output logic              hit_node,
  output logic              hit_gcall
);

  logic [ADDR_W-1:0] own_addr;

  assign own_addr  = {FIXED_BITS, prog, strap};
  assign hit_node  = (cand[ADDR_W:1] == own_addr);
  assign hit_gcall = (cand[ADDR_W:1] == '0) && !cand[0];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_node_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int MAX_BYTES  = 8,
  parameter bit STRETCH_EN = 1'b1,
  localparam int CNT_W = $clog2(BYTE_W),
  localparam int NB_W  = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  line_ev_t          ev,
  output logic [BYTE_W-1:0] addr_cand,
  input  logic              hit_node,
  input  logic              hit_gcall,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              sda_oe,
  output logic              scl_hold,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_first,
  output logic              rx_gcall,
  output logic              rx_end,
  output logic              tx_take
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [NB_W-1:0]  NB_MAX   = NB_W'(MAX_BYTES);

  tgt_state_e        state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [NB_W-1:0]   nbytes;
  logic              rd_mode;
  logic              matched;
  logic              gc_sel;
  logic              accept;
  logic              mack;
  logic              wr_seen;
  logic              room;
  logic [BYTE_W-1:0] shifted_in;

  assign shifted_in = {shreg[BYTE_W-2:0], ev.sda};
  assign addr_cand  = shifted_in;
  assign room       = (nbytes < NB_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      nbytes   <= '0;
      rd_mode  <= 1'b0;
      matched  <= 1'b0;
      gc_sel   <= 1'b0;
      accept   <= 1'b0;
      mack     <= 1'b0;
      wr_seen  <= 1'b0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_first <= 1'b0;
      rx_gcall <= 1'b0;
      rx_end   <= 1'b0;
      tx_take  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_first <= 1'b0;
      rx_end   <= 1'b0;
      tx_take  <= 1'b0;
      if (ev.start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        nbytes  <= '0;
        sda_oe  <= 1'b0;
        rx_end  <= wr_seen;
        wr_seen <= 1'b0;
      end else if (ev.stop) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        rx_end  <= wr_seen;
        wr_seen <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (ev.scl_rise) begin
              shreg <= shifted_in;
              if (bit_cnt == LAST_BIT) begin
                rd_mode <= ev.sda;
                matched <= hit_node | hit_gcall;
                gc_sel  <= hit_gcall;
                state   <= ST_ADDR_ACKW;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_ADDR_ACKW: begin
            if (ev.scl_fall) begin
              if (matched) begin
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev.scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= rd_mode ? ST_RD_LOAD : ST_WR_BIT;
            end
          end
          ST_WR_BIT: begin
            if (ev.scl_rise) begin
              shreg <= shifted_in;
              if (bit_cnt == LAST_BIT) begin
                state  <= ST_WR_ACKW;
                accept <= room;
                if (room) begin
                  rx_valid <= 1'b1;
                  rx_data  <= shifted_in;
                  rx_first <= (nbytes == '0);
                  rx_gcall <= gc_sel;
                  nbytes   <= nbytes + 1'b1;
                  wr_seen  <= 1'b1;
                end
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_WR_ACKW: begin
            if (ev.scl_fall) begin
              sda_oe <= accept;
              state  <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (ev.scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WR_BIT;
            end
          end
          ST_RD_LOAD: begin
            if (!room) begin
              shreg   <= '1;
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RD_BIT;
            end else if (tx_valid) begin
              shreg   <= tx_data;
              sda_oe  <= ~tx_data[BYTE_W-1];
              tx_take <= 1'b1;
              nbytes  <= nbytes + 1'b1;
              bit_cnt <= '0;
              state   <= ST_RD_BIT;
            end
          end
          ST_RD_BIT: begin
            if (ev.scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACKW;
              end else begin
                shreg   <= {shreg[BYTE_W-2:0], 1'b1};
                sda_oe  <= ~shreg[BYTE_W-2];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RD_ACKW: begin
            if (ev.scl_rise) begin
              mack  <= ~ev.sda;
              state <= ST_RD_ACKD;
            end
          end
          ST_RD_ACKD: begin
            if (ev.scl_fall) begin
              state <= mack ? ST_RD_LOAD : ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  generate
    if (STRETCH_EN) begin : g_stretch
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_hold <= 1'b0;
        end else begin
          scl_hold <= (state == ST_RD_LOAD) && !tx_valid && room
                      && !ev.start && !ev.stop;
        end
      end
    end else begin : g_no_stretch
      assign scl_hold = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/i2c_node_target.sv
module i2c_node_target
  import i2c_node_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int FIX_W       = 2,
  parameter logic [FIX_W-1:0] FIXED_BITS = 2'b11,
  parameter int MAX_BYTES   = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit STRETCH_EN  = 1'b1,
  localparam int PROG_W = ADDR_W - FIX_W - 1,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              scl_hold,
  input  logic [PROG_W-1:0] node_prog,
  input  logic              node_strap,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_first,
  output logic              rx_gcall,
  output logic              rx_end,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_take
);

  line_ev_t          line_ev;
  logic [BYTE_W-1:0] addr_cand;
  logic              hit_node;
  logic              hit_gcall;
  logic              scl_seen;
  logic              start_seen;

  assign scl_seen   = line_ev.scl;
  assign start_seen = line_ev.start;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .scl_i(scl_i),
    .sda_i(sda_i),
    .ev   (line_ev)
  );

  i2c_addr_match #(
    .ADDR_W    (ADDR_W),
    .FIX_W     (FIX_W),
    .FIXED_BITS(FIXED_BITS)
  ) u_match (
    .cand     (addr_cand),
    .prog     (node_prog),
    .strap    (node_strap),
    .hit_node (hit_node),
    .hit_gcall(hit_gcall)
  );

  i2c_target_fsm #(
    .BYTE_W    (BYTE_W),
    .MAX_BYTES (MAX_BYTES),
    .STRETCH_EN(STRETCH_EN)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ev       (line_ev),
    .addr_cand(addr_cand),
    .hit_node (hit_node),
    .hit_gcall(hit_gcall),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .sda_oe   (sda_oe),
    .scl_hold (scl_hold),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_first (rx_first),
    .rx_gcall (rx_gcall),
    .rx_end   (rx_end),
    .tx_take  (tx_take)
  );

endmodule

// File: rtl/i2c_node_target_chk.sv
module i2c_node_target_chk #(
  parameter int MAX_BYTES = 8
) (
  input logic clk,
  input logic rst,
  input logic scl_seen,
  input logic start_seen,
  input logic sda_oe,
  input logic scl_hold,
  input logic rx_valid,
  input logic rx_first,
  input logic rx_end,
  input logic tx_take,
  input logic tx_valid
);

  logic [7:0] xfer_cnt;

  always_ff @(posedge clk) begin
    if (rst || start_seen) begin
      xfer_cnt <= '0;
    end else if ((rx_valid || tx_take) && xfer_cnt != 8'hFF) begin
      xfer_cnt <= xfer_cnt + 1'b1;
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_seen)); // R10

  AST_HOLD_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> !scl_seen); // R7

  AST_FIRST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rx_first |-> rx_valid); // R11

  AST_TAKE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_take |-> $past(tx_valid)); // R11

  AST_END_APART_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    rx_end |-> !rx_valid); // R9

  AST_BYTE_CAP: assert property (@(posedge clk) disable iff (rst)
    xfer_cnt <= 8'(MAX_BYTES)); // R5

endmodule

bind i2c_node_target i2c_node_target_chk #(
  .MAX_BYTES(MAX_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_seen  (scl_seen),
  .start_seen(start_seen),
  .sda_oe    (sda_oe),
  .scl_hold  (scl_hold),
  .rx_valid  (rx_valid),
  .rx_first  (rx_first),
  .rx_end    (rx_end),
  .tx_take   (tx_take),
  .tx_valid  (tx_valid)
);

// File: tb/sim_i2c_node_target.sv
`timescale 1ns/1ps
module sim_i2c_node_target;

  localparam int HP = 25;
  localparam int QP = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       scl_i, sda_i, sda_oe, scl_hold;
  logic [3:0] node_prog = 4'b1010;
  logic       node_strap = 1'b1;
  logic       rx_valid, rx_first, rx_gcall, rx_end, tx_take;
  logic [7:0] rx_data, tx_data;
  logic       tx_en = 1'b1;

  logic [7:0] tx_mem [16];
  logic [3:0] tx_idx = '0;

  int n_rx = 0, n_end = 0, n_take = 0;
  logic [7:0] rx_log [64];
  logic       first_log [64];
  logic       gc_log [64];

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign scl_i   = m_scl & ~scl_hold;
  assign sda_i   = m_sda & ~sda_oe;
  assign tx_data = tx_mem[tx_idx];

  i2c_node_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe(sda_oe), .scl_hold(scl_hold),
    .node_prog(node_prog), .node_strap(node_strap),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
    .rx_gcall(rx_gcall), .rx_end(rx_end),
    .tx_data(tx_data), .tx_valid(tx_en), .tx_take(tx_take)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_log[n_rx % 64]    <= rx_data;
      first_log[n_rx % 64] <= rx_first;
      gc_log[n_rx % 64]    <= rx_gcall;
      n_rx <= n_rx + 1;
    end
    if (rx_end) n_end <= n_end + 1;
    if (tx_take) begin
      n_take <= n_take + 1;
      tx_idx <= tx_idx + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_i) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(QP); m_sda = 1'b1;
    tick(QP); m_scl = 1'b1;
    wait_scl_high();
    tick(HP); m_sda = 1'b0;
    tick(HP); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(QP); m_sda = 1'b0;
    tick(QP); m_scl = 1'b1;
    wait_scl_high();
    tick(HP); m_sda = 1'b1;
    tick(HP);
  endtask

  task automatic bit_out(input logic b);
    tick(QP); m_sda = b;
    tick(QP); m_scl = 1'b1;
    wait_scl_high();
    tick(HP); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(QP); m_sda = 1'b1;
    tick(QP); m_scl = 1'b1;
    wait_scl_high();
    tick(HP / 2); b = sda_i;
    tick(HP - HP / 2); m_scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(!give_ack);
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1;
    tick(10);
    chk(sda_oe == 1'b0 && scl_hold == 1'b0, "R1 outputs in reset", {sda_oe, scl_hold}, 0);
    rst = 1'b0;
    tick(20);
    chk(sda_oe == 1'b0 && scl_hold == 1'b0, "R1 idle outputs", {sda_oe, scl_hold}, 0);
    chk(n_rx == 0 && n_end == 0 && n_take == 0, "R1 no strobes", n_rx + n_end + n_take, 0);
  endtask

  // R2 R4 R9: node address 0x75 (1,1,1010,1), write 0x81 then 0x3C
  task automatic t_write_node();
    int b0 = n_rx, e0 = n_end;
    logic a;
    bus_start();
    put_byte(8'hEA, a); chk(a, "R2 own address ACK", a, 1);
    put_byte(8'h81, a); chk(a, "R4 data ACK 1", a, 1);
    put_byte(8'h3C, a); chk(a, "R4 data ACK 2", a, 1);
    bus_stop();
    tick(10);
    chk(n_rx - b0 == 2, "R4 byte count", n_rx - b0, 2);
    chk(rx_log[b0 % 64] == 8'h81, "R4 first byte value", rx_log[b0 % 64], 8'h81);
    chk(rx_log[(b0 + 1) % 64] == 8'h3C, "R4 second byte value", rx_log[(b0 + 1) % 64], 8'h3C);
    chk(first_log[b0 % 64] == 1'b1 && first_log[(b0 + 1) % 64] == 1'b0,
        "R4 first flag", {first_log[b0 % 64], first_log[(b0 + 1) % 64]}, 2'b10);
    chk(gc_log[b0 % 64] == 1'b0, "R3 node bytes not general call", gc_log[b0 % 64], 0);
    chk(n_end - e0 == 1, "R9 end strobe on STOP", n_end - e0, 1);
  endtask

  // R2: strap bit differs -> 0x74 not ours
  task automatic t_addr_miss();
    int b0 = n_rx, e0 = n_end;
    logic a;
    bus_start();
    put_byte(8'hE8, a); chk(!a, "R2 foreign address NACK", a, 0);
    put_byte(8'h55, a); chk(!a, "R2 foreign data not ACKed", a, 0);
    bus_stop();
    tick(10);
    chk(n_rx == b0 && n_end == e0, "R2 foreign transfer silent", n_rx - b0, 0);
  endtask

  // R3
  task automatic t_gcall();
    int b0 = n_rx;
    logic a;
    bus_start();
    put_byte(8'h00, a); chk(a, "R3 general call ACK", a, 1);
    put_byte(8'h06, a); chk(a, "R3 general call data ACK", a, 1);
    bus_stop();
    tick(10);
    chk(n_rx - b0 == 1 && rx_log[b0 % 64] == 8'h06, "R3 general call byte", rx_log[b0 % 64], 8'h06);
    chk(gc_log[b0 % 64] == 1'b1, "R3 general call flag", gc_log[b0 % 64], 1);
  endtask

  // R5
  task automatic t_cap();
    int b0 = n_rx, e0 = n_end;
    int acks = 0;
    logic a;
    bus_start();
    put_byte(8'hEA, a);
    for (int i = 0; i < 8; i++) begin
      put_byte(8'h10 + 8'(i), a);
      if (a) acks++;
    end
    put_byte(8'h99, a);
    chk(acks == 8, "R5 eight bytes ACKed", acks, 8);
    chk(!a, "R5 ninth byte NACK", a, 0);
    bus_stop();
    tick(10);
    chk(n_rx - b0 == 8, "R5 only eight reported", n_rx - b0, 8);
    chk(rx_log[(b0 + 7) % 64] == 8'h17, "R5 last accepted byte", rx_log[(b0 + 7) % 64], 8'h17);
    chk(n_end - e0 == 1, "R9 end after capped write", n_end - e0, 1);
  endtask

  // R6
  task automatic t_read();
    int t0 = n_take;
    logic a;
    logic [7:0] v;
    tx_mem[tx_idx]        = 8'hA5;
    tx_mem[tx_idx + 4'd1] = 8'h5A;
    tx_mem[tx_idx + 4'd2] = 8'hEE;
    bus_start();
    put_byte(8'hEB, a); chk(a, "R6 read address ACK", a, 1);
    get_byte(1'b1, v); chk(v == 8'hA5, "R6 read byte 1", v, 8'hA5);
    get_byte(1'b0, v); chk(v == 8'h5A, "R6 read byte 2", v, 8'h5A);
    tick(8);
    chk(sda_oe == 1'b0, "R6 SDA released after NACK", sda_oe, 0);
    bus_stop();
    tick(10);
    chk(n_take - t0 == 2, "R6 take count", n_take - t0, 2);
  endtask

  // R7
  task automatic t_stretch();
    logic a;
    logic [7:0] v;
    logic held;
    tx_en = 1'b0;
    tx_mem[tx_idx] = 8'hC3;
    bus_start();
    put_byte(8'hEB, a);
    fork
      get_byte(1'b0, v);
      begin
        tick(300);
        held = scl_hold;
        tx_en = 1'b1;
      end
    join
    chk(held == 1'b1, "R7 SCL held while source empty", held, 1);
    chk(v == 8'hC3, "R7 byte after stretch", v, 8'hC3);
    tick(8);
    chk(scl_hold == 1'b0, "R7 hold released", scl_hold, 0);
    bus_stop();
  endtask

  // R9
  task automatic t_empty();
    int b0 = n_rx, e0 = n_end, t0 = n_take;
    bus_start();
    bus_stop();
    tick(20);
    chk(n_rx == b0 && n_end == e0 && n_take == t0, "R9 empty message silent",
        (n_rx - b0) + (n_end - e0), 0);
  endtask

  // R8 R9
  task automatic t_restart();
    int b0 = n_rx, e0 = n_end;
    logic a;
    logic [7:0] v;
    tx_mem[tx_idx] = 8'h3E;
    bus_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start();
    put_byte(8'hEA, a); chk(a, "R8 address after mid-byte START", a, 1);
    put_byte(8'h11, a);
    bus_start();
    tick(10);
    chk(n_end - e0 == 1, "R9 end on repeated START", n_end - e0, 1);
    put_byte(8'hEB, a);
    get_byte(1'b0, v); chk(v == 8'h3E, "R8 read after repeated START", v, 8'h3E);
    bus_stop();
    tick(10);
    chk(n_rx - b0 == 1 && rx_log[b0 % 64] == 8'h11, "R8 byte after restart", rx_log[b0 % 64], 8'h11);
    chk(n_end - e0 == 1, "R9 no end for read transfer", n_end - e0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tx_mem[i] = 8'h00;
    fork
      begin
        t_reset();
        t_write_node();
        t_addr_miss();
        t_gcall();
        t_cap();
        t_read();
        t_stretch();
        t_empty();
        t_restart();
      end
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule